// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block is the control unit of a small stored-program processor. It is built around a read-only control store rather than decode gates. Each clock it reads one control word. The word drives ten datapath strobes and carries a two-bit field that tells the sequencer how to form the next micro-address. From reset the unit runs a three-word instruction fetch routine. Then it branches to a routine chosen by the opcode in the instruction register. At the end of that routine it returns to micro-address 0 and fetches the next instruction.

The strobes come straight from a buffer register that holds the last word read. They therefore change only on a clock edge and are free of glitches. The processor flags are an input. One sequencing code uses the zero flag to choose whether the routine carries on or goes back to fetch. This allows a conditional jump. Opcodes with no routine of their own go to a one-word routine that asserts nothing and then returns to fetch.

Top module: `micro_ctrl_seq`

## Requirements
- R1: While `rst_n` is low, `ctrl` is 0x000. The first clock edge after release presents the first fetch word.
- R2: The fetch routine presents 0x243, then 0x328, then 0x094, on three consecutive cycles.
- R3: `ctrl` bits, from bit 9 down to bit 0, are: PC onto bus 1, constant one onto bus 2, MBR onto bus 2, pass bus 1, add, pass bus 2, bus 3 into PC, bus 3 into IR, bus 3 into MAR, memory read.
- R4: The opcode is sampled only at the edge that presents 0x094, so during the cycle in which 0x328 is shown. A change to the opcode after that edge has no effect on the routine that follows.
- R5: Opcode 0 (no operation) gives one word of 0x000 and then the fetch routine.
- R6: Opcode 1 (jump) gives 0x098 (MBR to bus 2, pass bus 2, bus 3 into PC) and then the fetch routine.
- R7: Opcode 2 (load) gives 0x093 and then 0x001, and then the fetch routine.
- R8: Opcode 3 (jump if zero) with flag bit 0 (zero) set gives 0x000, then 0x098, then the fetch routine.
- R9: Opcode 3 with the zero flag clear gives 0x000 and then the fetch routine. The other flag bits have no effect.
- R10: Opcodes 4 to 15 give one word of 0x000 and then the fetch routine, with no other strobe asserted.
- R11: Instructions follow each other without reset. Each return to fetch dispatches on the opcode present during that fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Opcode field of the instruction register |
| flags | input | 4 | Processor status flags. Bit 0 is zero. |
| ctrl | output | 10 | Registered datapath strobes (bit order in R3) |

## Verification
The hardest case to reach is the timing of the opcode sample. The dispatch looks at the opcode one cycle before the third fetch word appears, not when the IR load strobe is shown. The stimulus sets an undefined opcode and waits until the third fetch word is visible. It then switches the opcode to the jump code and expects the empty routine, not the jump. For the zero-flag branch, the stimulus holds the flags across the dispatch and test cycles. It sets every flag except zero, so that a test of the wrong bit would take the branch.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

   localparam int SIG_W = 10;

   // strobe bit positions, MSB first
   localparam int B_PC_B1  = 9;
   localparam int B_ONE_B2 = 8;
   localparam int B_MBR_B2 = 7;
   localparam int B_PASS1  = 6;
   localparam int B_ADD    = 5;
   localparam int B_PASS2  = 4;
   localparam int B_B3_PC  = 3;
   localparam int B_B3_IR  = 2;
   localparam int B_B3_MAR = 1;
   localparam int B_READ   = 0;

   typedef enum logic [1:0] {
      SQ_INC  = 2'd0,
      SQ_DISP = 2'd1,
      SQ_RET  = 2'd2,
      SQ_TSTZ = 2'd3
   } seq_e;

   typedef struct packed {
      seq_e              seq;
      logic [SIG_W-1:0]  sig;
   } uword_t;

   // named control words
   localparam logic [SIG_W-1:0] W_FETCH0 = 10'h243;
   localparam logic [SIG_W-1:0] W_FETCH1 = 10'h328;
   localparam logic [SIG_W-1:0] W_FETCH2 = 10'h094;
   localparam logic [SIG_W-1:0] W_JUMP   = 10'h098;
   localparam logic [SIG_W-1:0] W_LDADR  = 10'h093;
   localparam logic [SIG_W-1:0] W_LDWAIT = 10'h001;
   localparam logic [SIG_W-1:0] W_IDLE   = 10'h000;

   // control-store layout
   localparam int A_FETCH0 = 0;
   localparam int A_FETCH1 = 1;
   localparam int A_FETCH2 = 2;
   localparam int A_NOP    = 3;
   localparam int A_JMP    = 4;
   localparam int A_LD0    = 5;
   localparam int A_LD1    = 6;
   localparam int A_BZ0    = 7;
   localparam int A_BZ1    = 8;
   localparam int A_UNDEF  = 9;
   localparam int A_LAST   = 9;

   // opcodes
   localparam int OP_NOP = 0;
   localparam int OP_JMP = 1;
   localparam int OP_LD  = 2;
   localparam int OP_BZ  = 3;

endpackage

// File: rtl/mcs_store.sv
module mcs_store
   import mcs_pkg::*;
#(
   parameter int UADDR_W = 4
) (
   input  logic [UADDR_W-1:0] uaddr,
   output uword_t             word
);

   always_comb begin
      word = '{seq: SQ_RET, sig: W_IDLE};
      case (int'(uaddr))
         A_FETCH0: word = '{seq: SQ_INC,  sig: W_FETCH0};
         A_FETCH1: word = '{seq: SQ_INC,  sig: W_FETCH1};
         A_FETCH2: word = '{seq: SQ_DISP, sig: W_FETCH2};
         A_NOP:    word = '{seq: SQ_RET,  sig: W_IDLE};
         A_JMP:    word = '{seq: SQ_RET,  sig: W_JUMP};
         A_LD0:    word = '{seq: SQ_INC,  sig: W_LDADR};
         A_LD1:    word = '{seq: SQ_RET,  sig: W_LDWAIT};
         A_BZ0:    word = '{seq: SQ_TSTZ, sig: W_IDLE};
         A_BZ1:    word = '{seq: SQ_RET,  sig: W_JUMP};
         A_UNDEF:  word = '{seq: SQ_RET,  sig: W_IDLE};
         default:  word = '{seq: SQ_RET,  sig: W_IDLE};
      endcase
   end

endmodule

// File: rtl/mcs_next_addr.sv
module mcs_next_addr
   import mcs_pkg::*;
#(
   parameter int UADDR_W = 4,
   parameter int OPC_W   = 4
) (
   input  seq_e               seq,
   input  logic [UADDR_W-1:0] uaddr,
   input  logic [OPC_W-1:0]   opcode,
   input  logic               zflag,
   output logic [UADDR_W-1:0] nxt
);

   logic [UADDR_W-1:0] disp_tgt;

   always_comb begin
      case (opcode)
         OPC_W'(OP_NOP): disp_tgt = UADDR_W'(A_NOP);
         OPC_W'(OP_JMP): disp_tgt = UADDR_W'(A_JMP);
         OPC_W'(OP_LD):  disp_tgt = UADDR_W'(A_LD0);
         OPC_W'(OP_BZ):  disp_tgt = UADDR_W'(A_BZ0);
         default:        disp_tgt = UADDR_W'(A_UNDEF);
      endcase
   end

   always_comb begin
      case (seq)
         SQ_INC:  nxt = uaddr + 1'b1;
         SQ_DISP: nxt = disp_tgt;
         SQ_TSTZ: nxt = zflag ? uaddr + 1'b1 : UADDR_W'(A_FETCH0);
         default: nxt = UADDR_W'(A_FETCH0);
      endcase
   end

endmodule

// File: rtl/micro_ctrl_seq.sv
module micro_ctrl_seq
   import mcs_pkg::*;
#(
   parameter int UADDR_W   = 4,
   parameter int OPC_W     = 4,
   parameter int FLAG_W    = 4,
   parameter int ZFLAG_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [FLAG_W-1:0] flags,
   output logic [SIG_W-1:0]  ctrl
);

   localparam int STORE_DEPTH = 1 << UADDR_W;

   generate
      if (STORE_DEPTH <= A_LAST) begin : g_bad_depth
         $error("micro_ctrl_seq: UADDR_W too small for control store");
      end
      if (OPC_W < 2) begin : g_bad_opc
         $error("micro_ctrl_seq: OPC_W must be at least 2");
      end
      if (ZFLAG_BIT >= FLAG_W || ZFLAG_BIT < 0) begin : g_bad_flag
         $error("micro_ctrl_seq: ZFLAG_BIT outside flags");
      end
   endgenerate

   logic [UADDR_W-1:0] uaddr_q;
   logic [UADDR_W-1:0] uaddr_d;
   uword_t             rom_word;
   uword_t             ubuf_q;

   mcs_store #(.UADDR_W(UADDR_W)) store_i (
      .uaddr (uaddr_q),
      .word  (rom_word)
   );

   mcs_next_addr #(.UADDR_W(UADDR_W), .OPC_W(OPC_W)) seq_i (
      .seq    (rom_word.seq),
      .uaddr  (uaddr_q),
      .opcode (opcode),
      .zflag  (flags[ZFLAG_BIT]),
      .nxt    (uaddr_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         uaddr_q <= UADDR_W'(A_FETCH0);
         ubuf_q  <= '{seq: SQ_INC, sig: W_IDLE};
      end else begin
         uaddr_q <= uaddr_d;
         ubuf_q  <= rom_word;
      end
   end

   assign ctrl = ubuf_q.sig;

   // R1: strobes quiet while held in reset
   always @(posedge clk) begin
      if (!rst_n) a_r1_reset_quiet: assert (ctrl == W_IDLE);
   end

   // R2: fetch words follow each other in order
   a_r2_fetch_step1: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl == W_FETCH0 |=> ctrl == W_FETCH1);
   a_r2_fetch_step2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl == W_FETCH1 |=> ctrl == W_FETCH2);

   // R6: jump dispatch and return
   a_r6_jump_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl == W_FETCH2 && $past(opcode) == OPC_W'(OP_JMP)) |=> ctrl == W_JUMP);
   a_r6_jump_return: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl == W_JUMP |=> ctrl == W_FETCH0);

   // R9: jump-if-zero falls back to fetch when zero is clear
   a_r9_bz_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl == W_FETCH2 && $past(opcode) == OPC_W'(OP_BZ) && !flags[ZFLAG_BIT])
      |=> (ctrl == W_IDLE) ##1 (ctrl == W_FETCH0));

   // R10: undefined opcodes emit nothing and return
   a_r10_undef_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl == W_FETCH2 && int'($past(opcode)) > OP_BZ)
      |=> (ctrl == W_IDLE) ##1 (ctrl == W_FETCH0));

endmodule

// File: tb/micro_ctrl_seq_tb.sv
module micro_ctrl_seq_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam logic [9:0] F0 = 10'h243;
   localparam logic [9:0] F1 = 10'h328;
   localparam logic [9:0] F2 = 10'h094;
   localparam logic [9:0] JW = 10'h098;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] opcode = '0;
   logic [3:0] flags = '0;
   logic [9:0] ctrl;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   micro_ctrl_seq dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .opcode (opcode),
      .flags  (flags),
      .ctrl   (ctrl)
   );

   task automatic chk(input logic [9:0] exp, input string req);
      n_chk++;
      if (ctrl !== exp) begin
         n_bad++;
         $display("FAIL %s: ctrl=%03h expected=%03h", req, ctrl, exp);
      end
   endtask

   task automatic step_chk(input logic [9:0] exp, input string req);
      @(negedge clk);
      chk(exp, req);
   endtask

   // reset with given opcode/flags, release on a falling edge
   task automatic start(input logic [3:0] op, input logic [3:0] fl);
      @(negedge clk);
      rst_n = 1'b0;
      opcode = op;
      flags = fl;
      repeat (2) @(negedge clk);
      chk(10'h000, "R1");
      rst_n = 1'b1;
   endtask

   task automatic fetch3();
      step_chk(F0, "R1/R2");
      step_chk(F1, "R2");
      step_chk(F2, "R2");
   endtask

   task automatic t_reset_and_bits();
      start(4'd0, 4'd0);
      fetch3();
      // R3: first fetch word asserts PC->bus1, pass1, bus3->MAR, read
      n_chk++;
      if (!(ctrl == F2 && F0[9] && F0[6] && F0[1] && F0[0])) begin
         n_bad++;
         $display("FAIL R3: ctrl=%03h expected=%03h", ctrl, F2);
      end
      step_chk(10'h000, "R5");
      step_chk(F0, "R5");
   endtask

   task automatic t_jump();
      start(4'd1, 4'd0);
      fetch3();
      step_chk(JW, "R6");
      step_chk(F0, "R6");
   endtask

   task automatic t_load();
      start(4'd2, 4'd0);
      fetch3();
      step_chk(10'h093, "R7");
      step_chk(10'h001, "R7");
      step_chk(F0, "R7");
   endtask

   task automatic t_bz_taken();
      start(4'd3, 4'b0001);
      fetch3();
      step_chk(10'h000, "R8");
      step_chk(JW, "R8");
      step_chk(F0, "R8");
   endtask

   task automatic t_bz_not_taken();
      start(4'd3, 4'b1110);
      fetch3();
      step_chk(10'h000, "R9");
      step_chk(F0, "R9");
   endtask

   task automatic t_undef();
      for (int op = 4; op < 16; op += 5) begin
         start(4'(op), 4'b1111);
         fetch3();
         step_chk(10'h000, "R10");
         step_chk(F0, "R10");
      end
   endtask

   task automatic t_late_opcode();
      start(4'd7, 4'd0);
      fetch3();
      opcode = 4'd1;   // changed after sample point: R4
      step_chk(10'h000, "R4");
      step_chk(F0, "R4");
   endtask

   task automatic t_back_to_back();
      start(4'd1, 4'd0);
      fetch3();
      step_chk(JW, "R11");
      step_chk(F0, "R11");
      opcode = 4'd2;
      step_chk(F1, "R11");
      step_chk(F2, "R11");
      step_chk(10'h093, "R11");
      step_chk(10'h001, "R11");
      opcode = 4'd3;
      flags = 4'b0001;
      step_chk(F0, "R11");
      step_chk(F1, "R11");
      step_chk(F2, "R11");
      step_chk(10'h000, "R11");
      step_chk(JW, "R11");
      step_chk(F0, "R11");
   endtask

   initial begin
      t_reset_and_bits();
      t_jump();
      t_load();
      t_bz_taken();
      t_bz_not_taken();
      t_undef();
      t_late_opcode();
      t_back_to_back();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: ctrl=%03h expected=finish", ctrl);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule